// File: doc/BRIEF.md
# Oversampled Serial Receiver with Deferred Disable

This block receives asynchronous serial characters in 8N1 format: one start bit, eight data bits sent least significant bit first, and one stop bit. It reads the line on a 16x oversample tick and stores each character in a 64-entry receive FIFO. Each FIFO entry holds the data byte and a framing-error bit. The host reads the FIFO through a show-ahead port: the head entry is always visible, and a read strobe removes it.

A disable input stops reception, but only at a character boundary. If the receiver is part-way through a character when disable rises, it finishes and stores that character, then halts. If it is idle when disable rises, it still takes exactly one more complete character, then halts. After disable is cleared, the receiver first waits until it sees the line high, and only then hunts for a start edge. The FIFO can be read at any time, whether the receiver is running or halted.

The controller is a state machine with six states:
- `ST_ARM`: wait for the line to be high.
- `ST_HUNT`: look for a falling start edge.
- `ST_START`: confirm the start bit at mid-bit.
- `ST_DATA`: sample eight data bits.
- `ST_STOP`: sample the stop bit and push the character.
- `ST_HALT`: stopped after a disable.

The transitions are:
- Reset to `ST_ARM`.
- `ST_ARM` to `ST_HUNT` when the line is high.
- `ST_HUNT` to `ST_START` when a tick sees the line low.
- `ST_START` back to `ST_HUNT` if the mid-bit sample is high (a glitch).
- `ST_START` to `ST_DATA` if the mid-bit sample is low.
- `ST_DATA` to `ST_STOP` after the eighth data bit.
- `ST_STOP` to `ST_HALT` when a disable is pending.
- `ST_STOP` to `ST_HUNT` on a good stop bit.
- `ST_STOP` to `ST_ARM` on a framing error.
- `ST_HALT` to `ST_ARM` when disable is cleared.

Top module: `uart_rx_gated`

## Requirements
- R1: After reset, the FIFO is empty (`fifo_empty_o`=1, `fifo_count_o`=0, `fifo_full_o`=0), `overrun_o` is 0, and the receiver is enabled.
- R2: An 8N1 character is received with bits LSB first, 16 oversample ticks per bit. Each data bit is sampled at its middle, and the received byte appears on `rd_data_o` when it reaches the FIFO head.
- R3: A stop bit sampled low stores the byte with `rd_ferr_o`=1. A stop bit sampled high stores it with `rd_ferr_o`=0.
- R4: If `rx_disable_i` rises while a character is being received, that character is stored correctly and no later character is stored while disable stays high.
- R5: If `rx_disable_i` rises while the receiver is idle, exactly one more complete character is stored and then reception stops.
- R6: When `rx_disable_i` is cleared while the line is high, the next character is received normally.
- R7: The FIFO is readable in any receiver state. `rd_en_i` removes the head entry, and `rd_en_i` on an empty FIFO leaves the count at 0.
- R8: A character that completes while the FIFO holds 64 entries is discarded, `overrun_o` pulses high for one cycle, and the stored entries are unchanged.
- R9: After re-enable with the line held low, no character is stored until the line has been seen high and a new start edge arrives.
- R10: A low pulse shorter than half a bit time is not taken as a start bit and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_disable_i | input | 1 | 1 = stop reception at the next character boundary |
| rd_en_i | input | 1 | Remove the FIFO head entry |
| rd_data_o | output | 8 | Data byte at the FIFO head |
| rd_ferr_o | output | 1 | Framing-error bit of the FIFO head entry |
| fifo_empty_o | output | 1 | FIFO holds no entries |
| fifo_full_o | output | 1 | FIFO holds 64 entries |
| fifo_count_o | output | 7 | Number of stored entries |
| overrun_o | output | 1 | One-cycle pulse when a character is dropped because the FIFO is full |

## Verification
The receive path is driven in several ways:
- Random bytes with random stop-bit values, which separate bit-order and sampling-point faults from framing-flag faults.
- Disable raised mid-character and raised while idle, which tell the "finish the current character" rule apart from the "take one more character" rule.
- Re-enable with the line held low and a short low glitch, which show whether the receiver hunts only after seeing a high line and confirms the start bit at mid-bit.
- A burst of 65 characters, which exposes the full-FIFO boundary and the overrun pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int DATA_W    = 8;
    localparam int OVERSAMPLE = 16;

    typedef enum logic [2:0] {
        ST_ARM,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HALT
    } rx_state_t;

    typedef struct packed {
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= d_i;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = OVERSAMPLE,
    parameter int NBITS   = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             tick_i,
    input  logic             disable_i,
    output logic             push_o,
    output rx_entry_t        push_entry_o,
    output logic             halted_o
);
    localparam int CNT_W  = $clog2(OS_RATE);
    localparam int BIT_W  = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE/2 - 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);

    rx_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BIT_W-1:0] bit_idx, bit_idx_n;
    logic [NBITS-1:0] shreg, shreg_n;
    logic             dis_latch, dis_latch_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_ARM;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            dis_latch <= 1'b0;
        end else begin
            state     <= state_n;
            cnt       <= cnt_n;
            bit_idx   <= bit_idx_n;
            shreg     <= shreg_n;
            dis_latch <= dis_latch_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n     = state;
        cnt_n       = cnt;
        bit_idx_n   = bit_idx;
        shreg_n     = shreg;
        dis_latch_n = (state == ST_HALT) ? 1'b0 : (dis_latch | disable_i);
        unique case (state)
            ST_ARM: begin
                if (line_i) state_n = ST_HUNT;
            end
            ST_HUNT: begin
                if (tick_i && !line_i) begin
                    state_n = ST_START;
                    cnt_n   = '0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (cnt == MID_CNT) begin
                        cnt_n     = '0;
                        bit_idx_n = '0;
                        state_n   = line_i ? ST_HUNT : ST_DATA;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (cnt == LAST_CNT) begin
                        cnt_n   = '0;
                        shreg_n = {line_i, shreg[NBITS-1:1]};
                        if (bit_idx == LAST_BIT) begin
                            state_n = ST_STOP;
                        end else begin
                            bit_idx_n = bit_idx + 1'b1;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (cnt == LAST_CNT) begin
                        cnt_n = '0;
                        if (dis_latch || disable_i) state_n = ST_HALT;
                        else if (line_i)             state_n = ST_HUNT;
                        else                         state_n = ST_ARM;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (!disable_i) state_n = ST_ARM;
            end
            default: state_n = ST_ARM;
        endcase
    end

    // outputs
    always_comb begin
        push_o            = (state == ST_STOP) && tick_i && (cnt == LAST_CNT);
        push_entry_o.data = shreg;
        push_entry_o.ferr = !line_i;
        halted_o          = (state == ST_HALT);
    end

    // R4/R5: a halted receiver with disable held must stay halted
    assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && disable_i) |=> (state == ST_HALT));

    // R6: clearing disable while halted leads to the arming state
    assert_reenable_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !disable_i) |=> (state == ST_ARM));

    // R9: hunting begins only after the line was seen high while arming
    assert_arm_needs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && $past(state) == ST_ARM) |-> $past(line_i));

    // R5: disable raised while idle still leaves the receiver running
    assert_idle_disable_defers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && disable_i) |=> (state != ST_HALT));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  rx_entry_t                  wr_entry_i,
    input  logic                       rd_i,
    output rx_entry_t                  head_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    assign do_wr = wr_i && (count != DEPTH_C);
    assign do_rd = rd_i && (count != '0);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_entry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign empty_o = (count == '0);
    assign full_o  = (count == DEPTH_C);
    assign count_o = count;

    // R8: occupancy never exceeds the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= DEPTH_C);

    // R8: a write into a full FIFO without a read leaves occupancy unchanged
    assert_full_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && full_o && !rd_i) |=> $stable(count_o));

    // R7: a read on an empty FIFO leaves it empty
    assert_empty_read_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && empty_o && !wr_i) |=> empty_o);
endmodule

// File: rtl/uart_rx_gated.sv
module uart_rx_gated
    import uart_rx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rx_i,
    input  logic                            os_tick_i,
    input  logic                            rx_disable_i,
    input  logic                            rd_en_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic                            rd_ferr_o,
    output logic                            fifo_empty_o,
    output logic                            fifo_full_o,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count_o,
    output logic                            overrun_o
);
    logic      line_s;
    logic      push;
    logic      halted;
    rx_entry_t push_entry;
    rx_entry_t head;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (line_s)
    );

    rx_frame_fsm #(.OS_RATE(OVERSAMPLE), .NBITS(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_s),
        .tick_i       (os_tick_i),
        .disable_i    (rx_disable_i),
        .push_o       (push),
        .push_entry_o (push_entry),
        .halted_o     (halted)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (push),
        .wr_entry_i (push_entry),
        .rd_i       (rd_en_i),
        .head_o     (head),
        .empty_o    (fifo_empty_o),
        .full_o     (fifo_full_o),
        .count_o    (fifo_count_o)
    );

    assign rd_data_o = head.data;
    assign rd_ferr_o = head.ferr;
    assign overrun_o = push && fifo_full_o;

    // R4: nothing is pushed while the receiver is halted
    assert_no_push_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !push);

    // R8: the overrun pulse lasts a single cycle
    assert_overrun_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> !overrun_o);
endmodule

// File: tb/sim_uart_rx_gated.sv
module sim_uart_rx_gated;
    localparam int BITCLK = 64;

    logic       clk = 0, rst_n = 0;
    logic       rx = 1, tick = 0, dis = 0, rd_en = 0;
    logic [7:0] rd_data;
    logic       rd_ferr, empty, full, overrun;
    logic [6:0] count;

    int checks = 0, errors = 0, ovr_pulses = 0, cyc = 0;
    bit done = 0;
    logic [8:0] expq[$];

    uart_rx_gated u0 (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .os_tick_i(tick),
        .rx_disable_i(dis), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rd_ferr_o(rd_ferr), .fifo_empty_o(empty), .fifo_full_o(full),
        .fifo_count_o(count), .overrun_o(overrun)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tick <= ((cyc % 4) == 3);
        if (rst_n && overrun) ovr_pulses <= ovr_pulses + 1;
    end

    function automatic logic [8:0] mk_entry(input logic [7:0] d, input logic stop);
        return {~stop, d};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stop);
        rx = 0; idle(BITCLK);
        for (int i = 0; i < 8; i++) begin rx = d[i]; idle(BITCLK); end
        rx = stop; idle(BITCLK);
        rx = 1; idle(BITCLK);
    endtask

    task automatic pop_check(input string req);
        logic [8:0] e;
        e = expq.pop_front();
        @(negedge clk);
        chk(req, rd_data, e[7:0]);
        chk(req, rd_ferr, e[8]);
        rd_en = 1; @(negedge clk); rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        idle(5); rst_n = 1; idle(2);
        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 count", count, 0);
        chk("R1 full", full, 0);
        chk("R1 overrun", overrun, 0);

        // R7 read on empty FIFO
        rd_en = 1; idle(1); rd_en = 0; idle(1);
        chk("R7 empty read", count, 0);

        // R2 directed patterns
        send(8'h55, 1); expq.push_back(mk_entry(8'h55, 1));
        send(8'h80, 1); expq.push_back(mk_entry(8'h80, 1));
        send(8'h01, 1); expq.push_back(mk_entry(8'h01, 1));
        chk("R2 count", count, 3);
        pop_check("R2"); pop_check("R2"); pop_check("R2");

        // R3 framing error, then a clean byte
        send(8'hA7, 0); expq.push_back(mk_entry(8'hA7, 0));
        send(8'h3C, 1); expq.push_back(mk_entry(8'h3C, 1));
        pop_check("R3"); pop_check("R3");

        // R2/R3 random
        for (int k = 0; k < 16; k++) begin
            logic [7:0] d; logic s;
            d = 8'($urandom); s = ($urandom % 5) != 0;
            send(d, s); expq.push_back(mk_entry(d, s));
            if (k % 3 == 2) while (expq.size() > 0) pop_check("R2 random");
        end
        while (expq.size() > 0) pop_check("R2 random");

        // R10 short glitch
        rx = 0; idle(16); rx = 1; idle(BITCLK * 12);
        chk("R10 glitch", count, 0);

        // R5 disable while idle
        dis = 1; idle(BITCLK * 2);
        send(8'hC3, 1); expq.push_back(mk_entry(8'hC3, 1));
        send(8'h99, 1);
        chk("R5 one more", count, 1);
        pop_check("R7 read while disabled");
        chk("R7 count after read", count, 0);

        // R6 re-enable on idle line
        dis = 0; idle(BITCLK);
        send(8'h6E, 1); expq.push_back(mk_entry(8'h6E, 1));
        chk("R6 count", count, 1);
        pop_check("R6");

        // R4 disable mid-character
        fork
            begin send(8'h4B, 1); end
            begin idle(BITCLK * 3 + 10); dis = 1; end
        join
        expq.push_back(mk_entry(8'h4B, 1));
        send(8'hD2, 1);
        send(8'h17, 1);
        chk("R4 count", count, 1);
        pop_check("R4");

        // R9 re-enable with line low
        rx = 0; idle(BITCLK);
        dis = 0; idle(BITCLK * 12);
        chk("R9 low line", count, 0);
        rx = 1; idle(BITCLK * 2);
        send(8'hE1, 1); expq.push_back(mk_entry(8'hE1, 1));
        chk("R9 count", count, 1);
        pop_check("R9");

        // R8 overrun
        for (int k = 0; k < 65; k++) begin
            logic [7:0] d;
            d = 8'(k * 7 + 3);
            send(d, 1);
            if (k < 64) expq.push_back(mk_entry(d, 1));
        end
        chk("R8 full", full, 1);
        chk("R8 count", count, 64);
        chk("R8 overrun pulses", ovr_pulses, 1);
        while (expq.size() > 0) pop_check("R8 contents");
        chk("R8 drained", empty, 1);

        finish_run();
    end
endmodule